// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a reconfigurable two-level logic core. Ten dedicated inputs and eight feedback signals are each expanded into a true line and a complement line. A stored connection matrix decides, for every product term, which of those lines take part in its AND. The block then combines fixed groups of terms with OR gates to form eight sum outputs. The same array also yields one enable term per output and two shared control terms, a synchronous preset and an asynchronous clear. These are intended for the output cells that sit next to the block.

Every connection means "this line must be high". A term with nothing connected is therefore always true. A term that connects both polarities of one signal can never be true. The matrix is written one term row per clock through a small configuration port, which has three operations: load a row, force a whole row to all-connected, or erase the entire array in a single cycle. Evaluation is purely combinational from the stored matrix. The outputs change only when an input changes or after a configuration write has been clocked in.

Top module: `sop_array_core`

## Requirements
- R1: Signal s drives line 2s with its true value and line 2s+1 with its complement. Signals 0..9 are `ded_in[0..9]` and signals 10..17 are `fb_in[0..7]`. A product term is true only when every line whose row bit is 1 is high.
- R2: A product term whose row holds no set bit evaluates true.
- R3: A product term whose row sets both line 2s and line 2s+1 of any signal s evaluates false whatever the inputs.
- R4: Sum output k is the OR of terms 8k through 8k+7, and no other term contributes to it.
- R5: Term 64+k drives `oe_term[k]`, term 72 drives `preset_term` and term 73 drives `clear_term`.
- R6: Operation 2'b00 (load) with `cfg_we` high copies `cfg_row` into the row addressed by `cfg_term` at the rising clock edge. The outputs show the new row after that edge and not before it.
- R7: Operation 2'b01 (kill) sets all 36 bits of the addressed row, so that term reads false and leaves its OR output unaffected.
- R8: Operation 2'b10 (erase) clears every row of the array in one cycle, whatever the address. Reset leaves the array in this same erased state, so every term is true.
- R9: A load or kill to a term index of 74 or more changes nothing. Operation 2'b11 changes nothing at any address.
- R10: While `cfg_we` stayed low in the previous cycle and the inputs hold steady, all outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, erases the matrix |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | Operation: 00 load, 01 kill, 10 erase, 11 no-op |
| cfg_term | input | 7 | Term index addressed by load or kill |
| cfg_row | input | 36 | Connection row for load, bit n is line n |
| ded_in | input | 10 | Dedicated logic inputs |
| fb_in | input | 8 | Feedback or bidirectional input signals |
| sum_out | output | 8 | OR of each group of eight sum terms |
| oe_term | output | 8 | Per-output enable terms |
| preset_term | output | 1 | Shared synchronous preset term |
| clear_term | output | 1 | Shared asynchronous clear term |

## Verification
Some behaviours are checked by assertions on every cycle:
- A row with a contradictory pair always yields a false term, and an empty row always yields a true one.
- Erase, load and kill land in the stored rows exactly one edge later, and illegal writes leave the matrix untouched.
- The outputs hold still when neither the inputs nor the configuration moved.

Other behaviours only the bench scenarios can show:
- The line numbering and the term-to-output grouping.
- The exact edge at which a new row becomes visible.
- That random sparse patterns give the same sums as an independent behavioural model under many input vectors.

// File: rtl/sop_pkg.sv
package sop_pkg;

   typedef enum logic [1:0] {
      SOP_LOAD  = 2'b00,
      SOP_KILL  = 2'b01,
      SOP_ERASE = 2'b10,
      SOP_NOP   = 2'b11
   } sop_op_e;

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store
   import sop_pkg::*;
#(
   parameter int N_TERM = 74,
   parameter int N_LINE = 36,
   parameter int AW     = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [1:0]               op,
   input  logic [AW-1:0]            term,
   input  logic [N_LINE-1:0]        row,
   output logic [N_TERM*N_LINE-1:0] conn_flat
);

   localparam logic [AW:0] TERM_LIMIT = (AW+1)'(N_TERM);

   logic [N_LINE-1:0] mem [N_TERM];
   logic              addr_ok;

   assign addr_ok = ({1'b0, term} < TERM_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < N_TERM; t++) mem[t] <= '0;
      end else if (we) begin
         for (int t = 0; t < N_TERM; t++) begin
            if (op == SOP_ERASE) begin
               mem[t] <= '0;
            end else if (term == AW'(t)) begin
               if (op == SOP_LOAD)      mem[t] <= row;
               else if (op == SOP_KILL) mem[t] <= '1;
            end
         end
      end
   end

   for (genvar t = 0; t < N_TERM; t++) begin : g_flat
      assign conn_flat[t*N_LINE +: N_LINE] = mem[t];
   end

   // R8: erase clears the whole array at the next edge
   assert_erase_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && op == SOP_ERASE) |=> (conn_flat == '0));

   // R6: a load lands in the addressed row at the next edge
   assert_load_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && op == SOP_LOAD && addr_ok) |=> (mem[$past(term)] == $past(row)));

   // R7: kill connects every line of the addressed row
   assert_kill_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && op == SOP_KILL && addr_ok) |=> (mem[$past(term)] == '1));

   // R9: out-of-range or no-op writes leave the matrix untouched
   assert_bad_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (op == SOP_NOP || (op != SOP_ERASE && !addr_ok))) |=> $stable(conn_flat));

endmodule

// File: rtl/sop_line_expand.sv
module sop_line_expand #(
   parameter int N_DED = 10,
   parameter int N_FB  = 8,
   localparam int N_SIG  = N_DED + N_FB,
   localparam int N_LINE = 2 * N_SIG
) (
   input  logic [N_DED-1:0]  ded_in,
   input  logic [N_FB-1:0]   fb_in,
   output logic [N_LINE-1:0] lines
);

   logic [N_SIG-1:0] sig;
   assign sig = {fb_in, ded_in};

   for (genvar s = 0; s < N_SIG; s++) begin : g_pair
      assign lines[2*s]   = sig[s];
      assign lines[2*s+1] = ~sig[s];
   end

endmodule

// File: rtl/sop_term_eval.sv
module sop_term_eval #(
   parameter int N_TERM = 74,
   parameter int N_LINE = 36
) (
   input  logic [N_LINE-1:0]        lines,
   input  logic [N_TERM*N_LINE-1:0] conn_flat,
   output logic [N_TERM-1:0]        terms
);

   // A term is true when every connected line is high; open lines count as high.
   for (genvar t = 0; t < N_TERM; t++) begin : g_term
      assign terms[t] = &(lines | ~conn_flat[t*N_LINE +: N_LINE]);
   end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
   parameter int N_OUT = 8,
   parameter int TPO   = 8,
   localparam int N_SUM = N_OUT * TPO
) (
   input  logic [N_SUM-1:0] sum_terms,
   output logic [N_OUT-1:0] sums
);

   for (genvar k = 0; k < N_OUT; k++) begin : g_or
      assign sums[k] = |sum_terms[k*TPO +: TPO];
   end

endmodule

// File: rtl/sop_array_core.sv
module sop_array_core
   import sop_pkg::*;
#(
   parameter int N_DED = 10,
   parameter int N_FB  = 8,
   parameter int N_OUT = 8,
   parameter int TPO   = 8,
   localparam int N_SIG   = N_DED + N_FB,
   localparam int N_LINE  = 2 * N_SIG,
   localparam int N_SUM   = N_OUT * TPO,
   localparam int IDX_OE  = N_SUM,
   localparam int IDX_PRE = N_SUM + N_OUT,
   localparam int IDX_CLR = IDX_PRE + 1,
   localparam int N_TERM  = IDX_CLR + 1,
   localparam int AW      = $clog2(N_TERM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_op,
   input  logic [AW-1:0]     cfg_term,
   input  logic [N_LINE-1:0] cfg_row,
   input  logic [N_DED-1:0]  ded_in,
   input  logic [N_FB-1:0]   fb_in,
   output logic [N_OUT-1:0]  sum_out,
   output logic [N_OUT-1:0]  oe_term,
   output logic              preset_term,
   output logic              clear_term
);

   if (N_DED < 1 || N_FB < 1 || N_OUT < 1 || TPO < 1) begin : g_bad_size
      $error("sop_array_core: every size parameter must be at least 1");
   end

   logic [N_TERM*N_LINE-1:0] conn_flat;
   logic [N_LINE-1:0]        lines;
   logic [N_TERM-1:0]        term_vec;

   sop_cfg_store #(.N_TERM(N_TERM), .N_LINE(N_LINE), .AW(AW)) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .op        (cfg_op),
      .term      (cfg_term),
      .row       (cfg_row),
      .conn_flat (conn_flat)
   );

   sop_line_expand #(.N_DED(N_DED), .N_FB(N_FB)) expand_i (
      .ded_in (ded_in),
      .fb_in  (fb_in),
      .lines  (lines)
   );

   sop_term_eval #(.N_TERM(N_TERM), .N_LINE(N_LINE)) eval_i (
      .lines     (lines),
      .conn_flat (conn_flat),
      .terms     (term_vec)
   );

   sop_or_plane #(.N_OUT(N_OUT), .TPO(TPO)) or_i (
      .sum_terms (term_vec[N_SUM-1:0]),
      .sums      (sum_out)
   );

   assign oe_term     = term_vec[IDX_OE +: N_OUT];
   assign preset_term = term_vec[IDX_PRE];
   assign clear_term  = term_vec[IDX_CLR];

   // Per-term properties of the connection semantics
   for (genvar t = 0; t < N_TERM; t++) begin : g_chk
      logic contra;
      logic empty;
      always_comb begin
         contra = 1'b0;
         for (int s = 0; s < N_SIG; s++)
            contra = contra | (conn_flat[t*N_LINE + 2*s] & conn_flat[t*N_LINE + 2*s + 1]);
      end
      assign empty = (conn_flat[t*N_LINE +: N_LINE] == '0);

      assert_contra_false_R3: assert property (@(posedge clk) disable iff (!rst_n)
         contra |-> !term_vec[t]);

      assert_open_true_R2: assert property (@(posedge clk) disable iff (!rst_n)
         empty |-> term_vec[t]);

      assert_kill_false_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_op == SOP_KILL && cfg_term == AW'(t)) |=> !term_vec[t]);
   end

   // R10: no write and steady inputs keep every output steady
   assert_hold_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_we) && $stable(ded_in) && $stable(fb_in))
         |-> $stable({sum_out, oe_term, preset_term, clear_term}));

endmodule

// File: tb/sop_array_core_tb_top.sv
module sop_array_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_op = 2'b11;
   logic [6:0]  cfg_term = '0;
   logic [35:0] cfg_row = '0;
   logic [9:0]  ded_in = '0;
   logic [7:0]  fb_in = '0;
   logic [7:0]  sum_out;
   logic [7:0]  oe_term;
   logic        preset_term;
   logic        clear_term;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   logic [35:0] ref_rows [0:73];

   always #4 clk = ~clk;

   sop_array_core dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
      .cfg_term(cfg_term), .cfg_row(cfg_row), .ded_in(ded_in), .fb_in(fb_in),
      .sum_out(sum_out), .oe_term(oe_term), .preset_term(preset_term),
      .clear_term(clear_term)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   function automatic logic ref_term(input int t);
      for (int l = 0; l < 36; l++) begin
         if (ref_rows[t][l]) begin
            int s = l / 2;
            logic v = (s < 10) ? ded_in[s] : fb_in[s-10];
            if (l % 2 == 1) v = ~v;
            if (!v) return 1'b0;
         end
      end
      return 1'b1;
   endfunction

   // Cycle-by-cycle reference model, compared after every rising edge
   always @(posedge clk) begin
      logic        s_we;
      logic [1:0]  s_op;
      logic [6:0]  s_addr;
      logic [35:0] s_row;
      logic [7:0]  e_sum, e_oe;
      s_we = cfg_we; s_op = cfg_op; s_addr = cfg_term; s_row = cfg_row;
      #2;
      if (!rst_n) begin
         for (int t = 0; t < 74; t++) ref_rows[t] = '0;
      end else begin
         if (s_we) begin
            if (s_op == 2'b10) for (int t = 0; t < 74; t++) ref_rows[t] = '0;
            else if (s_op == 2'b00 && s_addr < 74) ref_rows[s_addr] = s_row;
            else if (s_op == 2'b01 && s_addr < 74) ref_rows[s_addr] = '1;
         end
         e_sum = '0; e_oe = '0;
         for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 8; j++) e_sum[k] = e_sum[k] | ref_term(8*k + j);
            e_oe[k] = ref_term(64 + k);
         end
         chk("R4/R5 model", {14'd0, sum_out, oe_term, preset_term, clear_term},
             {14'd0, e_sum, e_oe, ref_term(72), ref_term(73)});
      end
   end

   task automatic cfg(input logic [1:0] op, input logic [6:0] addr, input logic [35:0] row);
      @(negedge clk);
      cfg_we = 1'b1; cfg_op = op; cfg_term = addr; cfg_row = row;
      @(negedge clk);
      cfg_we = 1'b0;
      #1;
   endtask

   task automatic drive(input logic [9:0] d, input logic [7:0] f);
      @(negedge clk);
      ded_in = d; fb_in = f;
      #1;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog got=running exp=done");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R8: reset leaves every term open, so all true
      chk("R8 reset sum", sum_out, 8'hff);
      chk("R8 reset oe", oe_term, 8'hff);
      chk("R8 reset ctl", {preset_term, clear_term}, 2'b11);

      // R7: kill every term
      for (int t = 0; t < 74; t++) cfg(2'b01, 7'(t), '0);
      chk("R7 killed sum", sum_out, 8'h00);
      chk("R7 killed oe", oe_term, 8'h00);
      chk("R7 killed ctl", {preset_term, clear_term}, 2'b00);

      // R6: load term 0 with line 0 only; visible after the edge, not before
      @(negedge clk);
      ded_in = 10'h001;
      cfg_we = 1'b1; cfg_op = 2'b00; cfg_term = 7'd0; cfg_row = 36'h1;
      #1 chk("R6 before edge", sum_out, 8'h00);
      @(posedge clk);
      #1 chk("R6 after edge", sum_out, 8'h01);
      @(negedge clk);
      cfg_we = 1'b0;

      // R1: line numbering
      drive(10'h000, 8'h00);
      chk("R1 ded0 low", sum_out, 8'h00);
      cfg(2'b00, 7'd8, 36'h1 << 21);   // fb0 complement
      cfg(2'b00, 7'd9, 36'h1 << 34);   // fb7 true
      chk("R1 fb0 low", sum_out, 8'h02);
      drive(10'h000, 8'h01);
      chk("R1 fb0 high", sum_out, 8'h00);
      drive(10'h000, 8'h81);
      chk("R1 fb7 high", sum_out, 8'h02);

      // R3: both polarities of ded2 on term 16
      cfg(2'b00, 7'd16, 36'h30);
      drive(10'h3ff, 8'h81);
      chk("R3 contra high", sum_out, 8'h03);
      drive(10'h000, 8'h00);
      chk("R3 contra low", sum_out, 8'h02);

      // R2: open term 24
      cfg(2'b00, 7'd24, 36'h0);
      chk("R2 open term", sum_out, 8'h0a);

      // R5: enable, preset and clear term positions
      cfg(2'b00, 7'd66, 36'h0);
      chk("R5 oe2", oe_term, 8'h04);
      cfg(2'b00, 7'd72, 36'h0);
      chk("R5 preset", {preset_term, clear_term}, 2'b10);
      cfg(2'b00, 7'd73, 36'h2);        // ded0 complement
      chk("R5 clear ded0 low", {preset_term, clear_term}, 2'b11);
      drive(10'h001, 8'h00);
      chk("R5 clear ded0 high", {preset_term, clear_term}, 2'b10);
      drive(10'h000, 8'h00);

      // R9: out-of-range and no-op writes
      cfg(2'b00, 7'd100, 36'h0);
      cfg(2'b00, 7'd74, 36'h0);
      cfg(2'b01, 7'd90, 36'h0);
      cfg(2'b11, 7'd17, 36'h0);
      chk("R9 sum unchanged", sum_out, 8'h0a);
      chk("R9 oe unchanged", oe_term, 8'h04);
      chk("R9 ctl unchanged", {preset_term, clear_term}, 2'b11);

      // R4: group boundaries
      cfg(2'b00, 7'd39, 36'h0);
      chk("R4 term39 group4", sum_out, 8'h1a);
      cfg(2'b00, 7'd63, 36'h0);
      chk("R4 term63 group7", sum_out, 8'h9a);
      cfg(2'b00, 7'd56, 36'h3);        // ded0 both polarities
      chk("R4 term56 contra", sum_out, 8'h9a);

      // R10: hold steady with no writes
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         #1 chk("R10 hold", {sum_out, oe_term}, {8'h9a, 8'h04});
      end

      // R8: erase whole array in one write
      cfg(2'b10, 7'd5, 36'h0);
      chk("R8 erase sum", sum_out, 8'hff);
      chk("R8 erase oe", oe_term, 8'hff);
      chk("R8 erase ctl", {preset_term, clear_term}, 2'b11);

      // Random sparse patterns against the model
      for (int pass = 0; pass < 4; pass++) begin
         for (int t = 0; t < 74; t++) begin
            logic [35:0] r;
            r = 36'({$urandom, $urandom}) & 36'({$urandom, $urandom})
              & 36'({$urandom, $urandom});
            if ($urandom_range(0, 9) == 0) cfg(2'b01, 7'(t), '0);
            else cfg(2'b00, 7'(t), r);
         end
         for (int v = 0; v < 100; v++) drive(10'($urandom), 8'($urandom));
      end

      @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      summary();
   end

endmodule